// File: doc/BRIEF.md
# Pipelined Carry-Save Tree Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product. It is meant for datapaths that need one product per clock at a high clock rate, where the latency can be a few cycles longer.

Each operand bit of `b_i` selects a shifted copy of `a_i`, which forms the partial-product rows. These rows are registered and then pass through a chain of registered layers of full adders. Each layer takes rows in groups of three and replaces every group with a sum row and a carry row. The carry row is shifted left by one column, so a carry moves one column per layer. When two rows are left, they sit in a register in front of the final adder.

The final adder is a block carry-lookahead adder, and it is pipelined as well. The first stage forms bit and block generate and propagate terms. A registered parallel-prefix network then resolves the block carries, one prefix level per stage. The last stage forms the local carries and the sum bits inside each block. A valid strobe travels beside the data. There is no stall input: a new operand pair may be presented on every clock.

Top module: `mul_csa_tree`

## Requirements
- R1: When `out_valid_o` is 1, `prod_o` equals the unsigned product of the `a_i` and `b_i` pair that was captured with `in_valid_i` = 1 exactly LAT clock edges earlier, in all 2W bits with no truncation.
- R2: LAT is 1 + L + clog2(2W/BLK) + 2, where L is the number of compressor layers needed to bring W rows down to two. Each layer turns n rows into 2*floor(n/3) + (n mod 3). For W = 16 and BLK = 4, LAT is 12. `out_valid_o` is `in_valid_i` delayed by exactly LAT edges.
- R3: Operand pairs presented on consecutive clocks each produce their own correct product on consecutive output cycles, with no stall and no interaction between them.
- R4: While `rst_ni` is 0, `out_valid_o` is 0 and `prod_o` is all zeros.
- R5: Every compressor layer keeps the arithmetic sum of its rows, modulo 2^(2W), from its input register to its output register, one cycle later.
- R6: The two rows that reach the final adder are held in a register. The adder's result equals their sum modulo 2^(2W), clog2(2W/BLK) + 2 cycles later.
- R7: For the corner operands 0, 1 and all ones, the products are 0, the other operand, and (2^W - 1)^2 respectively. Single-bit operands also give the correct result at every column.
- R8: A cycle with `in_valid_i` = 0 gives an output cycle with `out_valid_o` = 0 exactly LAT edges later, so gaps in the input stream appear unchanged in the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair on `a_i`/`b_i` is valid this cycle |
| a_i | input | W | Multiplicand, unsigned |
| b_i | input | W | Multiplier, unsigned |
| out_valid_o | output | 1 | `prod_o` holds a valid product |
| prod_o | output | 2W | Unsigned product |

## Verification
The all-ones operand pair creates the longest carry chains in both the tree and the final adder. A design with a broken block lookahead or prefix level would give wrong upper product bits only there. Walking single-bit operands place one partial-product bit in each column, which exposes a misrouted carry shift or a wrong row-to-column offset. A single isolated operand pair measures the latency edge by edge, so an extra or missing pipeline register shows up as a mismatch in the valid strobe. Streams that are back to back and streams with gaps check that results are not merged and that bubbles are not dropped when the pipeline is full.

// File: rtl/mul_csa_pkg.sv
package mul_csa_pkg;

  // rows left after one layer of 3:2 compressors
  function automatic int rows_next(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  function automatic int rows_at(input int n, input int layer);
    int r;
    r = n;
    for (int i = 0; i < layer; i++) r = rows_next(r);
    return r;
  endfunction

  function automatic int tree_layers(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rows_next(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/mul_pp_gen.sv
module mul_pp_gen #(
  parameter int W  = 16,
  parameter int PW = 2 * W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [W-1:0]           a_i,
  input  logic [W-1:0]           b_i,
  output logic [W-1:0][PW-1:0]   rows_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rows_o <= '0;
    end else begin
      for (int i = 0; i < W; i++)
        rows_o[i] <= b_i[i] ? (PW'(a_i) << i) : '0;
    end
  end

endmodule

// File: rtl/mul_csa_layer.sv
module mul_csa_layer #(
  parameter int PW       = 32,
  parameter int IN_ROWS  = 16,
  parameter int OUT_ROWS = 2 * (IN_ROWS / 3) + (IN_ROWS % 3)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IN_ROWS-1:0][PW-1:0]   rows_i,
  output logic [OUT_ROWS-1:0][PW-1:0]  rows_o
);

  localparam int NG   = IN_ROWS / 3;
  localparam int LEFT = IN_ROWS % 3;

  logic [OUT_ROWS-1:0][PW-1:0] nxt;

  always_comb begin
    nxt = '0;
    for (int g = 0; g < NG; g++) begin
      nxt[2*g]   = rows_i[3*g] ^ rows_i[3*g+1] ^ rows_i[3*g+2];
      // carry lands one column up; top carry is beyond the product width
      nxt[2*g+1] = ((rows_i[3*g] & rows_i[3*g+1]) |
                    (rows_i[3*g] & rows_i[3*g+2]) |
                    (rows_i[3*g+1] & rows_i[3*g+2])) << 1;
    end
    for (int k = 0; k < LEFT; k++)
      nxt[2*NG+k] = rows_i[3*NG+k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rows_o <= '0;
    else         rows_o <= nxt;
  end

endmodule

// File: rtl/mul_cla_pipe.sv
module mul_cla_pipe #(
  parameter int PW  = 32,
  parameter int BLK = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] x_i,
  input  logic [PW-1:0] y_i,
  output logic [PW-1:0] sum_o
);

  localparam int NB = PW / BLK;
  localparam int LV = $clog2(NB);

  logic [PW-1:0] bp [LV+1];
  logic [PW-1:0] bg [LV+1];
  logic [NB-1:0] kg [LV+1];
  logic [NB-1:0] kp [LV];

  logic [PW-1:0] p0, g0;
  logic [NB-1:0] blk_g, blk_p;

  assign p0 = x_i ^ y_i;
  assign g0 = x_i & y_i;

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      logic ga;
      logic pa;
      ga = 1'b0;
      pa = 1'b1;
      for (int j = 0; j < BLK; j++) begin
        ga = g0[k*BLK+j] | (p0[k*BLK+j] & ga);
        pa = pa & p0[k*BLK+j];
      end
      blk_g[k] = ga;
      blk_p[k] = pa;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp[0] <= '0;
      bg[0] <= '0;
      kg[0] <= '0;
      kp[0] <= '0;
    end else begin
      bp[0] <= p0;
      bg[0] <= g0;
      kg[0] <= blk_g;
      kp[0] <= blk_p;
    end
  end

  // block-level parallel prefix, one registered level per stage
  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int D = 1 << l;
    logic [NB-1:0] ng, np;

    for (genvar k = 0; k < NB; k++) begin : g_blk
      if (k >= D) begin : g_merge
        assign ng[k] = kg[l][k] | (kp[l][k] & kg[l][k-D]);
        assign np[k] = kp[l][k] & kp[l][k-D];
      end else begin : g_pass
        assign ng[k] = kg[l][k];
        assign np[k] = kp[l][k];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bp[l+1] <= '0;
        bg[l+1] <= '0;
        kg[l+1] <= '0;
      end else begin
        bp[l+1] <= bp[l];
        bg[l+1] <= bg[l];
        kg[l+1] <= ng;
      end
    end

    if (l + 1 < LV) begin : g_keep_p
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) kp[l+1] <= '0;
        else         kp[l+1] <= np;
      end
    end else begin : g_drop_p
      logic [NB-1:0] unused_np;
      assign unused_np = np;
    end
  end

  logic unused_cout;
  assign unused_cout = kg[LV][NB-1];

  logic [PW-1:0] sum_d;

  for (genvar k = 0; k < NB; k++) begin : g_sum
    logic           cin;
    logic [BLK-1:0] s;
    if (k == 0) begin : g_c0
      assign cin = 1'b0;
    end else begin : g_cn
      assign cin = kg[LV][k-1];
    end
    always_comb begin
      logic c;
      c = cin;
      for (int j = 0; j < BLK; j++) begin
        s[j] = bp[LV][k*BLK+j] ^ c;
        c    = bg[LV][k*BLK+j] | (bp[LV][k*BLK+j] & c);
      end
    end
    assign sum_d[k*BLK +: BLK] = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= sum_d;
  end

endmodule

// File: rtl/mul_csa_tree.sv
module mul_csa_tree
  import mul_csa_pkg::*;
#(
  parameter int W   = 16,
  parameter int BLK = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  output logic             out_valid_o,
  output logic [2*W-1:0]   prod_o
);

  localparam int PW  = 2 * W;
  localparam int NL  = tree_layers(W);
  localparam int LV  = $clog2(PW / BLK);
  localparam int LAT = 1 + NL + LV + 2;

  // lvl[l] holds the registered rows entering layer l; unused rows are zero
  logic [NL:0][W-1:0][PW-1:0] lvl;

  mul_pp_gen #(.W(W), .PW(PW)) u_pp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (a_i),
    .b_i    (b_i),
    .rows_o (lvl[0])
  );

  for (genvar l = 0; l < NL; l++) begin : g_layer
    localparam int RI = rows_at(W, l);
    localparam int RO = rows_next(RI);

    mul_csa_layer #(.PW(PW), .IN_ROWS(RI), .OUT_ROWS(RO)) u_csa (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rows_i (lvl[l][RI-1:0]),
      .rows_o (lvl[l+1][RO-1:0])
    );
    assign lvl[l+1][W-1:RO] = '0;
  end

  mul_cla_pipe #(.PW(PW), .BLK(BLK)) u_add (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (lvl[NL][0]),
    .y_i    (lvl[NL][1]),
    .sum_o  (prod_o)
  );

  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vpipe <= '0;
    else         vpipe <= {vpipe[LAT-2:0], in_valid_i};
  end

  assign out_valid_o = vpipe[LAT-1];

endmodule

// File: rtl/mul_csa_tree_chk.sv
module mul_csa_tree_chk
  import mul_csa_pkg::*;
#(
  parameter int W   = 16,
  parameter int BLK = 4,
  parameter int PW  = 2 * W,
  parameter int NL  = tree_layers(W)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [W-1:0]               a_i,
  input  logic [W-1:0]               b_i,
  input  logic                       out_valid_o,
  input  logic [PW-1:0]              prod_o,
  input  logic [NL:0][W-1:0][PW-1:0] lvl_i
);

  localparam int LV  = $clog2(PW / BLK);
  localparam int CL  = LV + 2;
  localparam int LAT = 1 + NL + CL;

  logic [PW-1:0] tot [NL+1];

  always_comb begin
    for (int l = 0; l <= NL; l++) begin
      tot[l] = '0;
      for (int r = 0; r < W; r++) tot[l] = tot[l] + lvl_i[l][r];
    end
  end

  logic [LAT-1:0] hv;
  logic [PW-1:0]  hp [LAT];
  logic [PW-1:0]  hs [CL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv <= '0;
      for (int i = 0; i < LAT; i++) hp[i] <= '0;
      for (int i = 0; i < CL; i++)  hs[i] <= '0;
    end else begin
      hv    <= {hv[LAT-2:0], in_valid_i};
      hp[0] <= PW'(a_i) * PW'(b_i);
      for (int i = 1; i < LAT; i++) hp[i] <= hp[i-1];
      hs[0] <= lvl_i[NL][0] + lvl_i[NL][1];
      for (int i = 1; i < CL; i++)  hs[i] <= hs[i-1];
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == hv[LAT-1]);

  p_bubble_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hv[LAT-1] |-> !out_valid_o);

  p_product_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> prod_o == hp[LAT-1]);

  p_final_add_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod_o == hs[CL-1]);

  for (genvar l = 0; l < NL; l++) begin : g_keep
    p_layer_sum_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tot[l+1] == $past(tot[l]));
  end

  p_reset_idle_r4: assert property (@(posedge clk_i)
    !rst_ni |=> (rst_ni || (!out_valid_o && prod_o == '0)));

endmodule

bind mul_csa_tree mul_csa_tree_chk #(.W(W), .BLK(BLK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .out_valid_o (out_valid_o),
  .prod_o      (prod_o),
  .lvl_i       (lvl)
);

// File: tb/tb_mul_csa_tree.sv
module tb_mul_csa_tree;

  localparam int  W     = 16;
  localparam int  PW    = 2 * W;
  localparam int  LAT   = 12;   // R2 with W = 16, BLK = 4
  localparam time CLK_P = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          out_valid_o;
  logic [PW-1:0] prod_o;

  mul_csa_tree #(.W(W), .BLK(4)) dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .out_valid_o (out_valid_o),
    .prod_o      (prod_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R4";
  bit    mon_en = 1'b0;
  bit    done = 1'b0;

  logic          hv [LAT];
  logic [PW-1:0] hp [LAT];

  task automatic check(input string req, input logic [PW-1:0] got,
                       input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // stream monitor: expected valid and product from the input history
  always @(posedge clk_i) begin
    #1;
    if (mon_en) begin
      for (int j = LAT - 1; j > 0; j--) begin
        hv[j] = hv[j-1];
        hp[j] = hp[j-1];
      end
      hv[0] = in_valid_i;
      hp[0] = PW'(a_i) * PW'(b_i);
      check({cur_req, " valid"}, PW'(out_valid_o), PW'(hv[LAT-1]));
      if (hv[LAT-1]) check({cur_req, " product"}, prod_o, hp[LAT-1]);
    end
  end

  task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    in_valid_i = v;
    a_i = a;
    b_i = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, '0);
  endtask

  task automatic t_reset();
    cur_req = "R4";
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 16'hffff, 16'hffff);
      check("R4 reset valid", PW'(out_valid_o), '0);
      check("R4 reset product", prod_o, '0);
    end
    drive(1'b0, '0, '0);
    for (int i = 0; i < LAT; i++) hv[i] = 1'b0;
    for (int i = 0; i < LAT; i++) hp[i] = '0;
    rst_ni = 1'b1;
    mon_en = 1'b1;
    idle(LAT + 2);
  endtask

  task automatic t_latency();
    int  n;
    bit  seen;
    cur_req = "R2";
    drive(1'b1, 16'd3, 16'd5);
    n = 0;
    seen = 1'b0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(posedge clk_i);
      #2;
      n++;
      seen = out_valid_o;
      if (seen) check("R1 isolated product", prod_o, 32'd15);
      @(negedge clk_i);
      in_valid_i = 1'b0;
    end
    check("R2 latency edges", PW'(n), PW'(LAT));
    idle(LAT + 2);
  endtask

  task automatic t_corners();
    logic [W-1:0] m;
    m = '1;
    cur_req = "R7";
    drive(1'b1, '0, 16'h1234);
    drive(1'b1, 16'hbeef, '0);
    drive(1'b1, 16'd1, 16'h8001);
    drive(1'b1, 16'h7ffe, 16'd1);
    drive(1'b1, m, m);
    drive(1'b1, m, 16'd1);
    drive(1'b1, m, '0);
    drive(1'b1, 16'd1, 16'd1);
    for (int i = 0; i < W; i++) drive(1'b1, W'(1) << i, W'(1) << (W - 1 - i));
    for (int i = 0; i < W; i++) drive(1'b1, W'(1) << i, m);
    idle(LAT + 2);
  endtask

  task automatic t_isolated();
    cur_req = "R1";
    drive(1'b1, 16'h00ff, 16'hff00);
    idle(3);
    drive(1'b1, 16'h8000, 16'h8000);
    idle(5);
    drive(1'b1, 16'ha5a5, 16'h5a5a);
    idle(LAT + 2);
  endtask

  task automatic t_stream();
    cur_req = "R3 R5 R6";
    for (int i = 0; i < 300; i++) drive(1'b1, W'($urandom), W'($urandom));
    idle(LAT + 2);
  endtask

  task automatic t_bubbles();
    logic [15:0] pat;
    pat = 16'b1011_0010_1110_0101;
    cur_req = "R8";
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 16; i++) drive(pat[i], W'($urandom), W'($urandom));
    idle(LAT + 2);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_isolated();
    t_stream();
    t_bubbles();
    finish_run();
  end

endmodule